// File: doc/BRIEF.md
# Ladder Rung Scan Engine

This block is a small hardware processor that runs a contact-and-coil ladder program from a 16-slot rung memory. It scans in a loop. Each pass freezes the synchronized input terminals into an input image word. It then solves the valid rungs one per clock, from slot 0 upward. Each solved rung writes its coil bit into either the output image or a bank of internal marker bits. When the pass ends, the whole output image is copied to the output terminals in a single clock, and a one-cycle scan-complete strobe marks that moment.

Each rung holds a coil target and two parallel branches of three contacts each. A contact tests one bit of the input image, the output image or the marker bank, and passes either when that bit is 1 or when it is 0. A rung that comes later sees the coil bits already written by earlier rungs in the same pass. This is how latches and chained logic are built. Rungs are written through a plain write port while the run input is low. With run low the engine halts and the terminals are forced off.

Top module: `ladder_scan_engine`

## Requirements
- R1: A synchronous active-low reset clears the output terminals, the output image, the marker bits, the input image, the synchronizer and every rung-valid flag. scan_done is low after reset.
- R2: While run is high the engine repeats a fixed sequence: sample the inputs, solve rungs in slot order, update the terminals. scan_done is high for exactly one cycle per scan, in the first cycle the new terminal values are visible.
- R3: A rung word is 55 bits: bit 54 is valid, bits 53:52 are the coil space, bits 51:48 are the coil bit index, and bits 47:0 hold the contacts. Contact c (0..2) of branch b (0..1) sits at bits (b*3+c)*8 +: 8, laid out as {enable, invert, space[1:0], index[3:0]}. With invert=0 the contact passes when its bit is 1, and with invert=1 it passes when its bit is 0. Space codes are 0 input image, 1 output image, 2 marker bits, 3 none (reads as 0).
- R4: A branch is true when it has at least one enabled contact and all of its enabled contacts pass, so disabled contacts are skipped. A rung is true when either branch is true. A branch with no enabled contact is false.
- R5: A valid rung writes its truth value (1 or 0) into the coil bit when the coil space is 1 (output image) or 2 (marker bits). A coil space of 0 or 3 writes nothing.
- R6: When several rungs name the same coil bit, the later slot decides the value left after the scan.
- R7: The output terminals change only in the cycle in which scan_done is high, or when run goes low.
- R8: Inputs pass through two flip-flops and are copied into the input image only in the sampling cycle. A change on the input pins made after scan_done is not seen by the scan that follows at once, only by the scan after that.
- R9: Contacts that read the output image or marker bits see the values written by earlier rungs of the same scan and the values kept from earlier scans.
- R10: A scan stops at the first slot whose valid bit is 0 or after slot 15. The scan period is k+3 cycles for k leading valid rungs (k<16) and 18 cycles for 16.
- R11: With run low, no scan runs, scan_done stays low and the output terminals read 0 from the next cycle on. The output image and marker bits keep their values, and the next scan after run rises continues from them.
- R12: When prog_we is high, prog_data is stored into slot prog_addr at the clock edge and is used from the next time that slot is solved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | High: scan continuously. Low: halt with terminals off |
| in_pins | input | 16 | Asynchronous discrete input terminals |
| prog_we | input | 1 | Rung write strobe |
| prog_addr | input | 4 | Rung slot to write |
| prog_data | input | 55 | Rung word (layout in R3) |
| out_pins | output | 16 | Discrete output terminals |
| scan_done | output | 1 | One-cycle strobe at each terminal update |

## Verification
A corrupt rung slot, a mis-decoded contact or a wrong coil write appears as a wrong output word at the very next scan_done that follows the scan where it happened. A wrong bit in the marker bank can stay hidden until a rung reads it. For that reason the bench runs latching programs that carry marker state across many scans. A pointer or state machine fault shows up at once as a wrong spacing between scan_done pulses, or as terminals moving between pulses. An input image loaded in the wrong cycle is caught one scan early or late by the two-scan input latency model.

// File: rtl/ladder_pkg.sv
// ladder_pkg: shared constants and enumerations for the ladder scan engine.
// Assumes a 2-bit space code in every contact and coil field.
package ladder_pkg;

    localparam int unsigned LAD_IO_W     = 16;
    localparam int unsigned LAD_RUNGS    = 16;
    localparam int unsigned LAD_BRANCHES = 2;
    localparam int unsigned LAD_CONTACTS = 3;

    // Bit space addressed by a contact or a coil.
    typedef enum logic [1:0] {
        SP_INPUT  = 2'd0,
        SP_OUTPUT = 2'd1,
        SP_MARKER = 2'd2,
        SP_NONE   = 2'd3
    } space_e;

    // Phases of one scan.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_SOLVE  = 2'd2,
        ST_UPDATE = 2'd3
    } scan_state_e;

endpackage

// File: rtl/ladder_sync.sv
// ladder_sync: two-stage synchronizer for the discrete input terminals.
// Assumes each bit is independent; there is no coherence across bits.
module ladder_sync #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Two back-to-back flops that settle metastable levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;

endmodule

// File: rtl/ladder_rung_store.sv
// ladder_rung_store: register file holding the rung program.
// The top bit of every word is a valid flag that resets to 0; the body
// is not reset. Read is combinational. The write port has no arbitration.
module ladder_rung_store #(
    parameter int unsigned N_SLOTS = 16,
    parameter int unsigned WORD_W  = 55,
    parameter int unsigned ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    localparam int unsigned BODY_W = WORD_W - 1;

    logic [N_SLOTS-1:0] valid_q;
    logic [BODY_W-1:0]  body_q [N_SLOTS];

    // Valid flags: cleared on reset, loaded from the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_addr] <= wr_data[WORD_W-1];
        end
    end

    // Rung bodies: plain storage loaded from the write port.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            body_q[wr_addr] <= wr_data[BODY_W-1:0];
        end
    end

    assign rd_data = {valid_q[rd_addr], body_q[rd_addr]};

    // R12: a write is visible on the next cycle at that slot.
    assert_prog_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_en) |=> ({valid_q[$past(wr_addr)], body_q[$past(wr_addr)]} == $past(wr_data)));

endmodule

// File: rtl/ladder_rung_eval.sv
// ladder_rung_eval: combinational solver for one rung word.
// Decodes each contact, selects its operand bit from the chosen image,
// ANDs the enabled contacts of a branch and ORs the branches.
// Assumes the word layout {valid, coil space, coil index, contacts}.
module ladder_rung_eval import ladder_pkg::*; #(
    parameter int unsigned IO_W      = 16,
    parameter int unsigned N_BRANCH  = 2,
    parameter int unsigned N_CONTACT = 3,
    parameter int unsigned IDX_W     = $clog2(IO_W),
    parameter int unsigned CT_W      = 4 + IDX_W,
    parameter int unsigned RUNG_W    = 1 + 2 + IDX_W + N_BRANCH * N_CONTACT * CT_W
) (
    input  logic [RUNG_W-1:0] rung_i,
    input  logic [IO_W-1:0]   in_img_i,
    input  logic [IO_W-1:0]   out_img_i,
    input  logic [IO_W-1:0]   mark_img_i,
    output logic              valid_o,
    output logic              true_o,
    output logic [1:0]        coil_space_o,
    output logic [IDX_W-1:0]  coil_idx_o
);

    localparam int unsigned CONTACT_BITS = N_BRANCH * N_CONTACT * CT_W;

    logic [N_BRANCH-1:0][N_CONTACT-1:0] ct_en;
    logic [N_BRANCH-1:0][N_CONTACT-1:0] ct_pass;
    logic [N_BRANCH-1:0]                br_true;

    for (genvar b = 0; b < N_BRANCH; b++) begin : g_branch
        for (genvar c = 0; c < N_CONTACT; c++) begin : g_contact
            localparam int unsigned LSB = (b * N_CONTACT + c) * CT_W;
            logic [CT_W-1:0]  fld;
            logic [1:0]       sp;
            logic [IDX_W-1:0] ix;
            logic             opnd;

            // Field split of one contact.
            assign fld = rung_i[LSB +: CT_W];
            assign sp  = fld[IDX_W +: 2];
            assign ix  = fld[IDX_W-1:0];

            // Operand bit from the addressed image; space 3 reads 0.
            assign opnd = (sp == SP_INPUT)  ? in_img_i[ix]  :
                          (sp == SP_OUTPUT) ? out_img_i[ix] :
                          (sp == SP_MARKER) ? mark_img_i[ix] : 1'b0;

            // A disabled contact never blocks its branch.
            assign ct_en[b][c]   = fld[CT_W-1];
            assign ct_pass[b][c] = ~fld[CT_W-1] | (opnd ^ fld[CT_W-2]);
        end

        // Series AND of a branch, false when nothing is enabled.
        assign br_true[b] = (|ct_en[b]) & (&ct_pass[b]);
    end

    assign valid_o      = rung_i[RUNG_W-1];
    assign coil_space_o = rung_i[RUNG_W-2 -: 2];
    assign coil_idx_o   = rung_i[CONTACT_BITS +: IDX_W];
    assign true_o       = |br_true;

endmodule

// File: rtl/ladder_scan_engine.sv
// ladder_scan_engine: top of the ladder scan processor.
// Loops sample -> solve (one rung per cycle) -> update while run is high.
// Rung results go to an output image; terminals follow it only at update.
// Assumes the program is rewritten only while run is low.
module ladder_scan_engine import ladder_pkg::*; #(
    parameter int unsigned IO_W      = LAD_IO_W,
    parameter int unsigned N_RUNGS   = LAD_RUNGS,
    parameter int unsigned N_BRANCH  = LAD_BRANCHES,
    parameter int unsigned N_CONTACT = LAD_CONTACTS,
    parameter int unsigned IDX_W     = $clog2(IO_W),
    parameter int unsigned PTR_W     = $clog2(N_RUNGS),
    parameter int unsigned RUNG_W    = 1 + 2 + IDX_W + N_BRANCH * N_CONTACT * (4 + IDX_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [IO_W-1:0]   in_pins,
    input  logic              prog_we,
    input  logic [PTR_W-1:0]  prog_addr,
    input  logic [RUNG_W-1:0] prog_data,
    output logic [IO_W-1:0]   out_pins,
    output logic              scan_done
);

    localparam int unsigned CT_W     = 4 + IDX_W;
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(N_RUNGS - 1);

    scan_state_e       state;
    logic [PTR_W-1:0]  ptr;
    logic [IO_W-1:0]   in_sync;
    logic [IO_W-1:0]   in_img;
    logic [IO_W-1:0]   out_img;
    logic [IO_W-1:0]   mark_img;
    logic [IO_W-1:0]   out_q;
    logic              done_q;
    logic [RUNG_W-1:0] rung_word;
    logic              rung_valid;
    logic              rung_true;
    logic [1:0]        coil_space;
    logic [IDX_W-1:0]  coil_idx;
    logic              solve_write;

    ladder_sync #(.W(IO_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (in_pins),
        .sync_o  (in_sync)
    );

    ladder_rung_store #(
        .N_SLOTS (N_RUNGS),
        .WORD_W  (RUNG_W),
        .ADDR_W  (PTR_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (prog_we),
        .wr_addr (prog_addr),
        .wr_data (prog_data),
        .rd_addr (ptr),
        .rd_data (rung_word)
    );

    ladder_rung_eval #(
        .IO_W      (IO_W),
        .N_BRANCH  (N_BRANCH),
        .N_CONTACT (N_CONTACT),
        .IDX_W     (IDX_W),
        .CT_W      (CT_W),
        .RUNG_W    (RUNG_W)
    ) u_eval (
        .rung_i       (rung_word),
        .in_img_i     (in_img),
        .out_img_i    (out_img),
        .mark_img_i   (mark_img),
        .valid_o      (rung_valid),
        .true_o       (rung_true),
        .coil_space_o (coil_space),
        .coil_idx_o   (coil_idx)
    );

    assign solve_write = run && (state == ST_SOLVE) && rung_valid;

    // Scan sequencer: phase, rung pointer, terminal register and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            ptr    <= '0;
            out_q  <= '0;
            done_q <= 1'b0;
        end else if (!run) begin
            state  <= ST_IDLE;
            ptr    <= '0;
            out_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    state <= ST_SAMPLE;
                end
                ST_SAMPLE: begin
                    ptr   <= '0;
                    state <= ST_SOLVE;
                end
                ST_SOLVE: begin
                    if (!rung_valid || ptr == LAST_PTR) begin
                        state <= ST_UPDATE;
                    end else begin
                        ptr <= ptr + 1'b1;
                    end
                end
                ST_UPDATE: begin
                    out_q  <= out_img;
                    done_q <= 1'b1;
                    state  <= ST_SAMPLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Image tables: input snapshot at sample, coil writes while solving.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_img   <= '0;
            out_img  <= '0;
            mark_img <= '0;
        end else begin
            if (run && state == ST_SAMPLE) begin
                in_img <= in_sync;
            end
            if (solve_write && coil_space == SP_OUTPUT) begin
                out_img[coil_idx] <= rung_true;
            end
            if (solve_write && coil_space == SP_MARKER) begin
                mark_img[coil_idx] <= rung_true;
            end
        end
    end

    assign out_pins  = out_q;
    assign scan_done = done_q;

    // R2: the completion strobe lasts a single cycle.
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> !scan_done);

    // R7: while running, terminals hold between update strobes.
    assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !scan_done) |-> $stable(out_pins));

    // R11: halting turns the terminals off and silences the strobe.
    assert_halt_dark_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (out_pins == '0 && !scan_done));

    // R8: the input snapshot moves only out of the sampling phase.
    assert_sample_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SAMPLE) |=> $stable(in_img));

    // R5: a solved rung aimed at the output image lands there next cycle.
    assert_coil_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (solve_write && coil_space == SP_OUTPUT) |=> (out_img[$past(coil_idx)] == $past(rung_true)));

    // R10: an invalid slot ends the solve phase.
    assert_invalid_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && state == ST_SOLVE && !rung_valid) |=> (!run || state == ST_UPDATE));

endmodule

// File: tb/ladder_scan_engine_tb.sv
`timescale 1ns/1ps
module ladder_scan_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [15:0] in_pins = '0;
    logic        prog_we = 1'b0;
    logic [3:0]  prog_addr = '0;
    logic [54:0] prog_data = '0;
    logic [15:0] out_pins;
    logic        scan_done;

    int n_chk = 0;
    int n_fail = 0;

    // Reference state kept by the bench.
    logic [54:0] m_prog [16];
    logic [54:0] p_stage [16];
    logic [15:0] m_out = '0;
    logic [15:0] m_int = '0;
    logic [15:0] in_applied = '0;
    logic [15:0] in_lag = '0;
    bit          first_scan = 1'b1;

    always #10 clk = ~clk;

    ladder_scan_engine u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .in_pins   (in_pins),
        .prog_we   (prog_we),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .out_pins  (out_pins),
        .scan_done (scan_done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ct(input bit en, input bit inv, input logic [1:0] sp, input logic [3:0] ix);
        return {en, inv, sp, ix};
    endfunction

    function automatic logic [54:0] rung(input logic [1:0] csp, input logic [3:0] cix,
                                         input logic [23:0] b0, input logic [23:0] b1);
        return {1'b1, csp, cix, b1, b0};
    endfunction

    function automatic bit m_bit(input logic [1:0] sp, input logic [3:0] ix, input logic [15:0] img);
        case (sp)
            2'd0: return img[ix];
            2'd1: return m_out[ix];
            2'd2: return m_int[ix];
            default: return 1'b0;
        endcase
    endfunction

    function automatic int n_valid();
        for (int r = 0; r < 16; r++) begin
            if (!m_prog[r][54]) return r;
        end
        return 16;
    endfunction

    // One full scan of the reference model on a frozen input word.
    task automatic model_scan(input logic [15:0] img);
        for (int r = 0; r < 16; r++) begin
            logic [54:0] w;
            bit t;
            w = m_prog[r];
            if (!w[54]) break;
            t = 1'b0;
            for (int b = 0; b < 2; b++) begin
                bit any_en;
                bit all_ok;
                any_en = 1'b0;
                all_ok = 1'b1;
                for (int c = 0; c < 3; c++) begin
                    logic [7:0] f;
                    bit v;
                    f = w[(b*3+c)*8 +: 8];
                    if (f[7]) begin
                        any_en = 1'b1;
                        v = m_bit(f[5:4], f[3:0], img) ^ f[6];
                        if (!v) all_ok = 1'b0;
                    end
                end
                if (any_en && all_ok) t = 1'b1;
            end
            if (w[53:52] == 2'd1) m_out[w[51:48]] = t;
            if (w[53:52] == 2'd2) m_int[w[51:48]] = t;
        end
    endtask

    // Wait for the next strobe, check the scan, then apply new inputs.
    task automatic scan_step(input logic [15:0] nxt);
        int cyc;
        bit moved;
        int expp;
        logic [15:0] prev;
        cyc = 0;
        moved = 1'b0;
        prev = out_pins;
        do begin
            @(negedge clk);
            cyc++;
            if (!scan_done && out_pins != prev) moved = 1'b1;
        end while (!scan_done && cyc < 200);
        chk(cyc < 200, "R2 strobe timeout", cyc, 0);
        model_scan(in_lag);
        chk(out_pins == m_out, "R3 R4 R5 R6 R8 R9 output word", out_pins, m_out);
        chk(!moved, "R7 terminals moved between strobes", 32'(moved), 0);
        if (!first_scan) begin
            expp = (n_valid() == 16) ? 18 : n_valid() + 3;
            chk(cyc == expp, "R10 R2 scan period", cyc, expp);
        end
        first_scan = 1'b0;
        in_lag = in_applied;
        in_applied = nxt;
        in_pins = nxt;
    endtask

    task automatic settle(input logic [15:0] v);
        repeat (3) scan_step(v);
    endtask

    // Halt, rewrite all slots from p_stage, restart.
    task automatic load_prog();
        run = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(out_pins == 16'h0 && !scan_done, "R11 halted terminals", {out_pins, 15'h0, scan_done}, 0);
        for (int s = 0; s < 16; s++) begin
            prog_we = 1'b1;
            prog_addr = 4'(s);
            prog_data = p_stage[s];
            m_prog[s] = p_stage[s];
            @(negedge clk);
            chk(!scan_done, "R11 no strobe while halted", 32'(scan_done), 0);
        end
        prog_we = 1'b0;
        run = 1'b1;
        in_lag = in_applied;
        first_scan = 1'b1;
    endtask

    task automatic do_reset();
        in_pins = '0;
        in_applied = '0;
        in_lag = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_out = '0;
        m_int = '0;
        for (int s = 0; s < 16; s++) m_prog[s] = '0;
        first_scan = 1'b1;
        chk(out_pins == 16'h0, "R1 reset terminals", out_pins, 0);
        chk(!scan_done, "R1 reset strobe", 32'(scan_done), 0);
    endtask

    function automatic logic [54:0] rand_rung(input bit vld);
        logic [54:0] w;
        w = {$urandom, $urandom};
        w[54] = vld;
        return w;
    endfunction

    task automatic build_prog_a();
        for (int s = 0; s < 16; s++) p_stage[s] = '0;
        // seal-in latch on marker 0: (start | mark0) & !stop
        p_stage[0]  = rung(2'd2, 4'd0, {8'h0, ct(1,1,0,1), ct(1,0,0,0)}, {8'h0, ct(1,1,0,1), ct(1,0,2,0)});
        p_stage[1]  = rung(2'd1, 4'd0, {16'h0, ct(1,0,2,0)}, 24'h0);
        p_stage[2]  = rung(2'd1, 4'd1, {ct(1,0,0,4), ct(1,0,0,3), ct(1,0,0,2)}, 24'h0);
        p_stage[3]  = rung(2'd1, 4'd2, {16'h0, ct(1,0,0,5)}, {16'h0, ct(1,1,0,6)});
        p_stage[4]  = rung(2'd1, 4'd3, {16'h0, ct(1,0,0,7)}, 24'h0);
        p_stage[5]  = rung(2'd1, 4'd3, {16'h0, ct(1,1,0,7)}, 24'h0);
        p_stage[6]  = rung(2'd1, 4'd4, {16'h0, ct(1,0,1,1)}, 24'h0);
        p_stage[7]  = rung(2'd0, 4'd5, {16'h0, ct(1,0,0,8)}, 24'h0);
        p_stage[8]  = rung(2'd1, 4'd5, {16'h0, ct(1,0,0,5)}, 24'h0);
        p_stage[9]  = rung(2'd1, 4'd6, 24'h0, 24'h0);
        p_stage[10] = rung(2'd1, 4'd7, {8'h0, ct(1,0,0,10), ct(0,0,0,9)}, 24'h0);
        p_stage[11] = rung(2'd3, 4'd0, {16'h0, ct(1,0,0,11)}, 24'h0);
        p_stage[12] = rung(2'd1, 4'd8, {16'h0, ct(1,1,2,1)}, 24'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1ADD));
        run = 1'b1;
        do_reset();
        // R1: empty program keeps terminals dark with the shortest period
        scan_step(16'h0);
        scan_step(16'hFFFF);
        scan_step(16'hFFFF);
        chk(out_pins == 16'h0, "R1 empty program output", out_pins, 0);

        // R12: load the directed program through the write port
        build_prog_a();
        load_prog();
        settle(16'h0);
        chk(out_pins[8] == 1'b1, "R3 inverted contact on clear marker", 32'(out_pins[8]), 1);

        // R9: seal-in holds through a marker bit after start releases
        settle(16'h0001);
        settle(16'h0000);
        chk(out_pins[0] == 1'b1, "R9 seal-in held", 32'(out_pins[0]), 1);
        settle(16'h0002);
        settle(16'h0000);
        chk(out_pins[0] == 1'b0, "R9 seal-in broken by stop", 32'(out_pins[0]), 0);

        // R8: new inputs are one scan late
        scan_step(16'h001C);
        scan_step(16'h001C);
        chk(out_pins[1] == 1'b0, "R8 input not yet sampled", 32'(out_pins[1]), 0);
        scan_step(16'h001C);
        chk(out_pins[1] == 1'b1, "R8 input sampled next scan", 32'(out_pins[1]), 1);
        chk(out_pins[4] == 1'b1, "R9 output image read same scan", 32'(out_pins[4]), 1);

        // R6: later rung wins on a shared coil
        settle(16'h0080);
        chk(out_pins[3] == 1'b0, "R6 later rung wins", 32'(out_pins[3]), 0);
        settle(16'h0000);
        chk(out_pins[3] == 1'b1, "R6 later rung wins inverted", 32'(out_pins[3]), 1);

        // R5: a coil in the input space leaves the input image alone
        settle(16'h0100);
        chk(out_pins[5] == 1'b0, "R5 input-space coil ignored", 32'(out_pins[5]), 0);

        // R4: disabled contact skipped, empty branches false
        settle(16'h0400);
        chk(out_pins[7] == 1'b1, "R4 disabled contact skipped", 32'(out_pins[7]), 1);
        chk(out_pins[6] == 1'b0, "R4 empty branches false", 32'(out_pins[6]), 0);
        settle(16'h0040);
        chk(out_pins[2] == 1'b0, "R4 OR of two false branches", 32'(out_pins[2]), 0);

        // Random inputs on the directed program.
        for (int i = 0; i < 40; i++) scan_step(16'($urandom));

        // R11: image state survives a halt and reload
        settle(16'h0001);
        settle(16'h0000);
        load_prog();
        scan_step(16'h0000);
        chk(out_pins[0] == 1'b1, "R11 image kept across halt", 32'(out_pins[0]), 1);
        scan_step(16'h0000);

        // Random programs of random length.
        for (int p = 0; p < 40; p++) begin
            int k;
            k = $urandom_range(0, 16);
            for (int s = 0; s < 16; s++) p_stage[s] = rand_rung(s < k);
            load_prog();
            for (int i = 0; i < 8; i++) scan_step(16'($urandom));
        end

        // R1: reset mid-run clears program and images
        do_reset();
        scan_step(16'h0);
        scan_step(16'h0);
        chk(out_pins == 16'h0, "R1 cleared after second reset", out_pins, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule